// File: doc/BRIEF.md
# Configuration ROM Station Address Finder

This block recovers the station MAC address from a byte-wide configuration ROM that holds a chain of variable-length tuples. A start request first turns on ROM access with a control-register write. The block then walks the chain from a fixed base address, reading each tuple's four header bytes. A tuple whose signature marks it as the network-address record has its six address bytes copied into a 48-bit result register.

Each header carries a link length. A tuple that does not match is skipped by jumping over that many bytes plus two. The walk gives up when it reaches a zero link or when the next tuple would start at or past the scan ceiling. The result is a `done` level, a `found` flag and the address. All three hold until the next start.

The ROM read port is assumed to return data exactly one cycle after a read strobe. The block issues at most one read per cycle.

Top module: `tscan_mac_finder`

## Requirements
- R1: After reset, `done`, `found` and `mac_addr` are zero, and neither `rom_rd` nor `rom_ctrl_we` is asserted while no scan is running.
- R2: A start accepted while idle produces, in the next cycle, exactly one write on `rom_ctrl_we` with `rom_ctrl_wdata` equal to 16'h1000 (bit 12 set, ROM enable). No ROM read comes before that write.
- R3: The first tuple header is read from byte address 0x100. Header byte offsets are 0 = tuple code, 1 = link length, 2 = data identifier, 3 = data count. They are read in consecutive cycles, one byte per cycle, and each byte is used only after its one-cycle read latency.
- R4: A tuple matches when its code is 0x22, its identifier is 0x04 and its count is 0x06. On a match the bytes at tuple offsets 4 to 9 are read. The byte at offset 4 lands in `mac_addr[47:40]` and the byte at offset 9 in `mac_addr[7:0]`. `found` and `done` then rise together.
- R5: A tuple that does not match, with a non-zero link L, is followed by a tuple starting at its own address plus L plus 2.
- R6: A tuple whose link byte is zero ends the scan with `done`=1, `found`=0 and `mac_addr`=0, even if its signature matches.
- R7: When the next tuple address would be 0x1F7 or higher, the scan ends with `done`=1 and `found`=0, and no byte at or above that address is read. A next address of 0x1F6 is still scanned.
- R8: A tuple that does not match costs exactly 4 ROM reads. The matching tuple costs exactly 10 ROM reads.
- R9: `done`, `found` and `mac_addr` hold their values until a start is accepted. A start raised while a scan is in progress, including in its final cycle, is ignored.
- R10: A start accepted while idle with `done` high clears `done`, `found` and `mac_addr` in the following cycle and runs a fresh scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a scan; accepted only while idle |
| rom_ctrl_we | output | 1 | Write strobe to the ROM control register |
| rom_ctrl_wdata | output | 16 | Control word; bit 12 enables ROM access |
| rom_rd | output | 1 | ROM byte read strobe |
| rom_addr | output | ADDR_W | ROM byte address for the read |
| rom_data | input | 8 | ROM byte, valid one cycle after `rom_rd` |
| done | output | 1 | Scan finished; held until the next accepted start |
| found | output | 1 | The address tuple was located |
| mac_addr | output | 48 | Recovered station address, first ROM byte in the top octet |

## Verification
The collision of interest is a new start request arriving in the very cycle the scan commits its result. In that cycle the controller is still busy, so the request must be dropped while `done` rises. The bench provokes this by counting cycles from an accepted start on a zero-link chain and raising `start` exactly in the evaluation cycle. It judges the outcome by seeing `done` still high one cycle later with `found` low and the ROM read count unchanged. A follow-up start issued once the block is idle must then clear the result and rescan.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_HEAD,
        ST_HWAIT,
        ST_EVAL,
        ST_BODY,
        ST_BWAIT,
        ST_PUBLISH
    } scan_state_t;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] link;
        logic [7:0] ident;
        logic [7:0] count;
    } tuple_hdr_t;

    localparam int HDR_BYTES  = 4;
    localparam int MAC_BYTES  = 6;
    localparam int MAC_W      = 8 * MAC_BYTES;
    localparam int TUPLE_SPAN = HDR_BYTES + MAC_BYTES;
    localparam int OFS_W      = $clog2(TUPLE_SPAN);
    localparam int ROM_EN_BIT = 12;
    localparam int CTRL_W     = 16;

    localparam logic [7:0] NETADDR_CODE  = 8'h22;
    localparam logic [7:0] NETADDR_IDENT = 8'h04;
    localparam logic [7:0] NETADDR_COUNT = 8'h06;

    function automatic logic is_netaddr(tuple_hdr_t h);
        return (h.code == NETADDR_CODE) && (h.ident == NETADDR_IDENT) &&
               (h.count == NETADDR_COUNT);
    endfunction

endpackage

// File: rtl/tscan_capture.sv
module tscan_capture
    import tscan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [7:0]           rom_data,
    output tuple_hdr_t           hdr,
    output logic [MAC_W-1:0]     mac_sh
);

    logic             rd_q;
    logic [OFS_W-1:0] ofs_q;

    // Tag each read with its offset so the returning byte is steered correctly.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            ofs_q <= '0;
        end else begin
            rd_q  <= rd;
            ofs_q <= ofs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr    <= '0;
            mac_sh <= '0;
        end else if (rd_q) begin
            case (ofs_q)
                OFS_W'(0): hdr.code  <= rom_data;
                OFS_W'(1): hdr.link  <= rom_data;
                OFS_W'(2): hdr.ident <= rom_data;
                OFS_W'(3): hdr.count <= rom_data;
                default:   mac_sh    <= {mac_sh[MAC_W-9:0], rom_data};
            endcase
        end
    end

    // Returned bytes always belong to an offset inside one tuple.
    assert_ofs_range_R3: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> (ofs_q < OFS_W'(TUPLE_SPAN)));

endmodule

// File: rtl/tscan_ctrl.sv
module tscan_ctrl
    import tscan_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BASE   = 256,
    parameter int LIMIT  = 503
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  tuple_hdr_t           hdr,
    input  logic [MAC_W-1:0]     mac_sh,
    output logic                 rom_rd,
    output logic [ADDR_W-1:0]    rom_addr,
    output logic [OFS_W-1:0]     ofs,
    output logic                 ctrl_we,
    output logic [CTRL_W-1:0]    ctrl_wdata,
    output logic                 done,
    output logic                 found,
    output logic [MAC_W-1:0]     mac
);

    localparam int NW = ADDR_W + 1;
    localparam logic [OFS_W-1:0] HDR_LAST  = OFS_W'(HDR_BYTES - 1);
    localparam logic [OFS_W-1:0] BODY_LAST = OFS_W'(TUPLE_SPAN - 1);

    scan_state_t       state;
    logic [ADDR_W-1:0] cur;
    logic [NW-1:0]     nxt;

    // One bit wider than the address so a long link cannot wrap below the ceiling.
    assign nxt = {1'b0, cur} + NW'(hdr.link) + NW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= ADDR_W'(BASE);
            ofs   <= '0;
            done  <= 1'b0;
            found <= 1'b0;
            mac   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ENABLE;
                    cur   <= ADDR_W'(BASE);
                    ofs   <= '0;
                    done  <= 1'b0;
                    found <= 1'b0;
                    mac   <= '0;
                end
                ST_ENABLE: state <= ST_HEAD;
                ST_HEAD: begin
                    ofs <= ofs + 1'b1;
                    if (ofs == HDR_LAST) state <= ST_HWAIT;
                end
                ST_HWAIT: state <= ST_EVAL;
                ST_EVAL: begin
                    if (hdr.link == 8'h00) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (is_netaddr(hdr)) begin
                        ofs   <= OFS_W'(HDR_BYTES);
                        state <= ST_BODY;
                    end else if (nxt >= NW'(LIMIT)) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cur   <= nxt[ADDR_W-1:0];
                        ofs   <= '0;
                        state <= ST_HEAD;
                    end
                end
                ST_BODY: begin
                    ofs <= ofs + 1'b1;
                    if (ofs == BODY_LAST) state <= ST_BWAIT;
                end
                ST_BWAIT: state <= ST_PUBLISH;
                ST_PUBLISH: begin
                    mac   <= mac_sh;
                    found <= 1'b1;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rom_rd     = (state == ST_HEAD) || (state == ST_BODY);
        rom_addr   = cur + ADDR_W'(ofs);
        ctrl_we    = (state == ST_ENABLE);
        ctrl_wdata = ctrl_we ? CTRL_W'(1 << ROM_EN_BIT) : '0;
    end

    // R2: an accepted start is followed by the enable write, with no read yet.
    assert_enable_first_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (ctrl_we && !rom_rd));

    // R3: no read below the scan base.
    assert_read_floor_R3: assert property (@(posedge clk) disable iff (rst)
        rom_rd |-> (rom_addr >= ADDR_W'(BASE)));

    // R7: a header read never starts at or past the ceiling.
    assert_head_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && ofs == '0) |-> (rom_addr < ADDR_W'(LIMIT)));

    // R4: a found result is always a finished one.
    assert_found_done_R4: assert property (@(posedge clk) disable iff (rst)
        found |-> done);

    // R9: the result holds while no start arrives.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(found) && $stable(mac)));

    // R10: an accepted start wipes the previous result.
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (!done && !found && mac == '0));

endmodule

// File: rtl/tscan_mac_finder.sv
module tscan_mac_finder
    import tscan_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BASE   = 256,
    parameter int LIMIT  = 503
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rom_ctrl_we,
    output logic [15:0]       rom_ctrl_wdata,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              done,
    output logic              found,
    output logic [47:0]       mac_addr
);

    tuple_hdr_t       hdr;
    logic [MAC_W-1:0] mac_sh;
    logic [OFS_W-1:0] ofs;

    tscan_ctrl #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .LIMIT  (LIMIT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hdr        (hdr),
        .mac_sh     (mac_sh),
        .rom_rd     (rom_rd),
        .rom_addr   (rom_addr),
        .ofs        (ofs),
        .ctrl_we    (rom_ctrl_we),
        .ctrl_wdata (rom_ctrl_wdata),
        .done       (done),
        .found      (found),
        .mac        (mac_addr)
    );

    tscan_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .rd       (rom_rd),
        .ofs      (ofs),
        .rom_data (rom_data),
        .hdr      (hdr),
        .mac_sh   (mac_sh)
    );

    // R2: the enable write and a ROM read never share a cycle.
    assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_rd, rom_ctrl_we}));

    // R1: a running scan never reports completion.
    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        (rom_rd || rom_ctrl_we) |-> !done);

endmodule

// File: tb/test_tscan_mac_finder.sv
module test_tscan_mac_finder;

    localparam int ADDR_W = 10;
    localparam int ROM_N  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              rom_ctrl_we;
    logic [15:0]       rom_ctrl_wdata;
    logic              rom_rd;
    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic              done;
    logic              found;
    logic [47:0]       mac_addr;

    logic [7:0] mem [ROM_N];
    logic       rom_on;
    int total = 0;
    int bad = 0;
    int reads = 0;
    int wr_cnt = 0;
    int max_addr = 0;
    logic order_bad = 1'b0;

    always #4 clk = ~clk;

    tscan_mac_finder #(.ADDR_W(ADDR_W)) i_tscan_mac_finder (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .rom_ctrl_we    (rom_ctrl_we),
        .rom_ctrl_wdata (rom_ctrl_wdata),
        .rom_rd         (rom_rd),
        .rom_addr       (rom_addr),
        .rom_data       (rom_data),
        .done           (done),
        .found          (found),
        .mac_addr       (mac_addr)
    );

    // ROM model: one-cycle read latency, returns 0xFF until enabled.
    always @(posedge clk) begin
        if (rst) rom_on <= 1'b0;
        else if (rom_ctrl_we && rom_ctrl_wdata[12]) rom_on <= 1'b1;
        if (rom_rd) rom_data <= rom_on ? mem[rom_addr] : 8'hFF;
    end

    always @(negedge clk) begin
        if (rom_rd) begin
            reads++;
            if (int'(rom_addr) > max_addr) max_addr = int'(rom_addr);
            if (!rom_on) order_bad = 1'b1;
        end
        if (rom_ctrl_we) begin
            wr_cnt++;
            if (rom_ctrl_wdata != 16'h1000) order_bad = 1'b1;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < ROM_N; i++) mem[i] = 8'h00;
    endtask

    task automatic put_tuple(int a, logic [7:0] code, logic [7:0] link,
                             logic [7:0] id, logic [7:0] cnt, logic [47:0] m);
        mem[a] = code; mem[a+1] = link; mem[a+2] = id; mem[a+3] = cnt;
        for (int i = 0; i < 6; i++) mem[a+4+i] = m[47-8*i -: 8];
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic zero_counts();
        reads = 0; wr_cnt = 0; max_addr = 0; order_bad = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check("R9 done reached", {63'd0, done}, 64'd1);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 found", {63'd0, found}, 64'd0);
        check("R1 mac", {16'd0, mac_addr}, 64'd0);
        check("R1 rd/we", {62'd0, rom_rd, rom_ctrl_we}, 64'd0);
    endtask

    task automatic t_direct();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h22, 8'h08, 8'h04, 8'h06, 48'h0A1B2C3D4E5F);
        pulse_start(); wait_done();
        check("R4 found", {63'd0, found}, 64'd1);
        check("R4 mac order", {16'd0, mac_addr}, 64'h0A1B2C3D4E5F);
        check("R2 one enable write", 64'(wr_cnt), 64'd1);
        check("R2 enable before reads", {63'd0, order_bad}, 64'd0);
        check("R8 reads single tuple", 64'(reads), 64'd10);
        check("R3 last addr from base", 64'(max_addr), 64'h109);
    endtask

    task automatic t_restart();
        // Follows t_direct without reset: R10 clear on accepted start.
        zero_counts();
        mem[16'h104] = 8'h77;
        pulse_start();
        check("R10 done cleared", {63'd0, done}, 64'd0);
        check("R10 found cleared", {63'd0, found}, 64'd0);
        check("R10 mac cleared", {16'd0, mac_addr}, 64'd0);
        wait_done();
        check("R10 rescan mac", {16'd0, mac_addr}, 64'h771B2C3D4E5F);
    endtask

    task automatic t_chain();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'h05, 8'h00, 8'h00, 48'h0);
        put_tuple(16'h107, 8'h22, 8'h08, 8'h04, 8'h06, 48'h112233445566);
        pulse_start(); wait_done();
        check("R5 chained match", {16'd0, mac_addr}, 64'h112233445566);
        check("R8 reads skip+match", 64'(reads), 64'd14);
    endtask

    task automatic t_sig();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h22, 8'h04, 8'h05, 8'h06, 48'hFFFFFFFFFFFF);
        put_tuple(16'h106, 8'h22, 8'h04, 8'h04, 8'h07, 48'hEEEEEEEEEEEE);
        put_tuple(16'h10C, 8'h22, 8'h04, 8'h04, 8'h06, 48'hA0A1A2A3A4A5);
        pulse_start(); wait_done();
        check("R4 signature match", {16'd0, mac_addr}, 64'hA0A1A2A3A4A5);
        check("R4 found after skips", {63'd0, found}, 64'd1);
        check("R8 reads two skips", 64'(reads), 64'd18);
    endtask

    task automatic t_link0();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'h00, 8'h00, 8'h00, 48'h0);
        put_tuple(16'h102, 8'h22, 8'h08, 8'h04, 8'h06, 48'h123456789ABC);
        pulse_start(); wait_done();
        check("R6 link zero found", {63'd0, found}, 64'd0);
        check("R6 link zero mac", {16'd0, mac_addr}, 64'd0);
        check("R6 link zero reads", 64'(reads), 64'd4);
    endtask

    task automatic t_match_link0();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h22, 8'h00, 8'h04, 8'h06, 48'h123456789ABC);
        pulse_start(); wait_done();
        check("R6 matching link zero found", {63'd0, found}, 64'd0);
        check("R6 matching link zero reads", 64'(reads), 64'd4);
    endtask

    task automatic t_limit();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'hF5, 8'h00, 8'h00, 48'h0);
        put_tuple(16'h1F7, 8'h22, 8'h04, 8'h04, 8'h06, 48'h5555AAAA5555);
        pulse_start(); wait_done();
        check("R7 ceiling found", {63'd0, found}, 64'd0);
        check("R7 no read past ceiling", 64'(max_addr), 64'h103);
    endtask

    task automatic t_edge();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'hF4, 8'h00, 8'h00, 48'h0);
        put_tuple(16'h1F6, 8'h22, 8'h04, 8'h04, 8'h06, 48'hC0FFEE123456);
        pulse_start(); wait_done();
        check("R7 last legal tuple", {16'd0, mac_addr}, 64'hC0FFEE123456);
        check("R7 last legal reads", 64'(reads), 64'd14);
    endtask

    task automatic t_busy_start();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'h05, 8'h00, 8'h00, 48'h0);
        put_tuple(16'h107, 8'h22, 8'h08, 8'h04, 8'h06, 48'h0102030405AB);
        pulse_start();
        repeat (3) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        check("R9 busy start mac", {16'd0, mac_addr}, 64'h0102030405AB);
        check("R9 busy start reads", 64'(reads), 64'd14);
        check("R2 busy start no second enable", 64'(wr_cnt), 64'd1);
    endtask

    task automatic t_start_at_finish();
        do_reset(); clear_mem(); zero_counts();
        put_tuple(16'h100, 8'h01, 8'h00, 8'h00, 8'h00, 48'h0);
        pulse_start();                    // accepted at edge k
        repeat (6) @(negedge clk);        // now between edges k+6 and k+7
        start = 1'b1;                     // sampled in the finishing cycle
        @(negedge clk); start = 1'b0;
        check("R9 finish-cycle done", {63'd0, done}, 64'd1);
        check("R9 finish-cycle found", {63'd0, found}, 64'd0);
        @(negedge clk);
        check("R9 start dropped", {63'd0, done}, 64'd1);
        check("R9 no extra reads", 64'(reads), 64'd4);
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_direct();
        t_restart();
        t_chain();
        t_sig();
        t_link0();
        t_match_link0();
        t_limit();
        t_edge();
        t_busy_start();
        t_start_at_finish();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule